// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KB window of 32-bit control and identification registers on a zero-wait-state register bus with setup and access phases. Software uses it to manage a set of secure-debug enable bits through separate set and clear aliases. It can read and change the recorded cause of the last reset and a reset mask, and it can keep a value in a retention register. It also programs the boot vector, the CPU wait control and the wake-up controller control. A write-only register lets software request a system reset. A fixed bank of twelve identification words sits at the top of the window. Every stored register value drives an output port. The reset request leaves the block as a one-cycle pulse. Acting on these outputs is left to the surrounding logic.

A small bus-phase state machine accepts a transfer only when an access phase directly follows a setup phase. It has four states. ST_IDLE means no select. ST_SETUP means a setup phase was seen. ST_ACCESS means a transfer was accepted on the last edge. ST_STRAY means an access phase arrived without a setup phase.

The transitions out of ST_IDLE, ST_ACCESS and ST_STRAY are the same: to ST_IDLE when select is low, to ST_SETUP on select without enable, and to ST_STRAY on select with enable. From ST_SETUP the machine goes to ST_IDLE when select is low and stays in ST_SETUP while enable is low. With select and enable both high it moves to ST_ACCESS, and that cycle is the accepted transfer.

Writes take effect on the edge that ends the accepted access phase. Narrow accesses are widened to 32 bits by filling with zeros. An error strobe flags accesses that make no sense for the target offset.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the reset-cause register holds 1 and the boot vector holds 0x10000000. The debug status, reset mask, retention, CPU wait and wake control registers hold 0, and the reset request and error strobes are low.
- R2: The debug status register is at offset 0x000 and is read-only. Writing ones at offset 0x004 sets the matching status bits and leaves the others unchanged. Writing ones at offset 0x008 clears the matching bits.
- R3: Reads of offsets 0x004, 0x008 and 0x108 return zero and raise the error strobe.
- R4: A write to offset 0x108 with bit 9 set raises the reset request for exactly one cycle, the cycle after the accepted write. Writes to that offset with bit 9 clear raise no request, whatever the other bits hold.
- R5: The registers at 0x100 (reset cause), 0x104 (reset mask), 0x10C (retention), 0x110 (boot vector), 0x118 (CPU wait) and 0x120 (wake control) read back the last value written. Each value also appears on its output port.
- R6: Offset 0x11C always reads zero. A write to it changes nothing and raises the error strobe.
- R7: Offsets 0xFD0 to 0xFFC, in ascending word order, read 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. A write to any of them is ignored and raises the error strobe.
- R8: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register. Both raise the error strobe.
- R9: Size code 0 is a byte access, 1 is a halfword and 2 or 3 is a word. A narrow write stores the low 8 or 16 bits of the write data, zero-extended, into the addressed word. A narrow read returns the low 8 or 16 bits of the word, zero-extended.
- R10: The error strobe is high for exactly one cycle, the cycle after the accepted transfer. It is high only for an unmapped offset, a write to a read-only offset or a read of a write-only offset, and stays low for every other transfer.
- R11: The ready signal is high only in an access phase that directly follows a setup phase. An access phase without a setup phase is not ready and changes no register.
- R12: A write takes effect on the edge that ends its access phase, so a read in the next transfer returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset within the window |
| pwdata | input | DATA_W | Write data |
| psize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| prdata | output | DATA_W | Read data, valid while pready is high |
| pready | output | 1 | Transfer accepted this cycle |
| err_pulse | output | 1 | One-cycle strobe for a bad access |
| swrst_req | output | 1 | One-cycle software reset request |
| sdbg_status | output | DATA_W | Secure-debug enable bits |
| rst_cause | output | DATA_W | Reset-cause record |
| rst_mask | output | DATA_W | Reset mask |
| retain | output | DATA_W | General retention value |
| boot_vec | output | DATA_W | Boot vector |
| cpu_wait | output | DATA_W | CPU wait control |
| wake_ctrl | output | DATA_W | Wake-up controller control |

## Verification
The assertions assume the master drives the bus legally: select stays low during reset, and address, direction, size and write data stay stable across a setup phase and its access phase. They also assume every transfer spends at least one cycle in setup, so two accepted transfers never fall on neighbouring edges. The bench drives every transfer as one setup cycle followed by one access cycle and drops select between transfers. It breaks these rules only once, in the test of an access phase that has no setup phase. That test uses a write to a plain register, where no assertion depends on the missing setup cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_IDX_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_STRAY  = 2'd3
    } bus_st_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } acc_size_e;

    // word indices (byte offset / 4)
    localparam logic [WORD_IDX_W-1:0] W_DBG_STAT  = 10'h000;
    localparam logic [WORD_IDX_W-1:0] W_DBG_SET   = 10'h001;
    localparam logic [WORD_IDX_W-1:0] W_DBG_CLR   = 10'h002;
    localparam logic [WORD_IDX_W-1:0] W_RST_CAUSE = 10'h040;
    localparam logic [WORD_IDX_W-1:0] W_RST_MASK  = 10'h041;
    localparam logic [WORD_IDX_W-1:0] W_SWRST     = 10'h042;
    localparam logic [WORD_IDX_W-1:0] W_RETAIN    = 10'h043;
    localparam logic [WORD_IDX_W-1:0] W_BOOTVEC   = 10'h044;
    localparam logic [WORD_IDX_W-1:0] W_CPUWAIT   = 10'h046;
    localparam logic [WORD_IDX_W-1:0] W_RSVD      = 10'h047;
    localparam logic [WORD_IDX_W-1:0] W_WAKECTL   = 10'h048;
    localparam logic [WORD_IDX_W-1:0] W_ID_FIRST  = 10'h3F4;
    localparam logic [WORD_IDX_W-1:0] W_ID_LAST   = 10'h3FF;

    localparam int SWRST_BIT = 9;

    localparam logic [31:0] RST_CAUSE_INIT = 32'h0000_0001;
    localparam logic [31:0] BOOTVEC_INIT   = 32'h1000_0000;

    typedef struct packed {
        logic mapped;
        logic rd_ok;
        logic wr_ok;
    } acc_class_t;

    function automatic acc_class_t classify(input logic [WORD_IDX_W-1:0] w);
        acc_class_t c;
        c = '{mapped: 1'b0, rd_ok: 1'b0, wr_ok: 1'b0};
        if (w >= W_ID_FIRST && w <= W_ID_LAST) begin
            c = '{mapped: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0};
        end else begin
            case (w)
                W_DBG_STAT, W_RSVD:
                    c = '{mapped: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0};
                W_DBG_SET, W_DBG_CLR, W_SWRST:
                    c = '{mapped: 1'b1, rd_ok: 1'b0, wr_ok: 1'b1};
                W_RST_CAUSE, W_RST_MASK, W_RETAIN, W_BOOTVEC, W_CPUWAIT, W_WAKECTL:
                    c = '{mapped: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1};
                default:
                    c = '{mapped: 1'b0, rd_ok: 1'b0, wr_ok: 1'b0};
            endcase
        end
        return c;
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] v;
        case (idx)
            4'd0:    v = 8'h04;
            4'd4:    v = 8'h54;
            4'd5:    v = 8'hB8;
            4'd6:    v = 8'h0B;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'hF0;
            4'd10:   v = 8'h05;
            4'd11:   v = 8'hB1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_bus_fsm.sv
module sysctl_bus_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic err_cond,
    input  logic rst_cond,
    output logic accept,
    output logic err_pulse,
    output logic swrst_req
);

    bus_st_e st_q;
    bus_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SETUP: begin
                if (!psel)         st_d = ST_IDLE;
                else if (!penable) st_d = ST_SETUP;
                else               st_d = ST_ACCESS;
            end
            ST_IDLE, ST_ACCESS, ST_STRAY: begin
                if (!psel)         st_d = ST_IDLE;
                else if (!penable) st_d = ST_SETUP;
                else               st_d = ST_STRAY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // accepted transfer: access phase directly after a setup phase
    assign accept = (st_q == ST_SETUP) && psel && penable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            swrst_req <= 1'b0;
        end else begin
            err_pulse <= accept && err_cond;
            swrst_req <= accept && rst_cond;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WORD_IDX_W-1:0] word,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     sdbg_q,
    output logic [DATA_W-1:0]     cause_q,
    output logic [DATA_W-1:0]     mask_q,
    output logic [DATA_W-1:0]     retain_q,
    output logic [DATA_W-1:0]     boot_q,
    output logic [DATA_W-1:0]     wait_q,
    output logic [DATA_W-1:0]     wake_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdbg_q   <= '0;
            cause_q  <= DATA_W'(RST_CAUSE_INIT);
            mask_q   <= '0;
            retain_q <= '0;
            boot_q   <= DATA_W'(BOOTVEC_INIT);
            wait_q   <= '0;
            wake_q   <= '0;
        end else if (wr_en) begin
            case (word)
                W_DBG_SET:   sdbg_q   <= sdbg_q | wdata;
                W_DBG_CLR:   sdbg_q   <= sdbg_q & ~wdata;
                W_RST_CAUSE: cause_q  <= wdata;
                W_RST_MASK:  mask_q   <= wdata;
                W_RETAIN:    retain_q <= wdata;
                W_BOOTVEC:   boot_q   <= wdata;
                W_CPUWAIT:   wait_q   <= wdata;
                W_WAKECTL:   wake_q   <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [WORD_IDX_W-1:0] word,
    input  logic [DATA_W-1:0]     size_mask,
    input  logic [DATA_W-1:0]     sdbg_q,
    input  logic [DATA_W-1:0]     cause_q,
    input  logic [DATA_W-1:0]     mask_q,
    input  logic [DATA_W-1:0]     retain_q,
    input  logic [DATA_W-1:0]     boot_q,
    input  logic [DATA_W-1:0]     wait_q,
    input  logic [DATA_W-1:0]     wake_q,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] raw;
    logic [3:0]        id_idx;

    assign id_idx = word[3:0] - 4'd4;

    always_comb begin
        raw = '0;
        if (word >= W_ID_FIRST && word <= W_ID_LAST) begin
            raw = DATA_W'(id_byte(id_idx));
        end else begin
            case (word)
                W_DBG_STAT:  raw = sdbg_q;
                W_RST_CAUSE: raw = cause_q;
                W_RST_MASK:  raw = mask_q;
                W_RETAIN:    raw = retain_q;
                W_BOOTVEC:   raw = boot_q;
                W_CPUWAIT:   raw = wait_q;
                W_WAKECTL:   raw = wake_q;
                default:     raw = '0;
            endcase
        end
    end

    assign rdata = raw & size_mask;

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [1:0]        psize,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              err_pulse,
    output logic              swrst_req,
    output logic [DATA_W-1:0] sdbg_status,
    output logic [DATA_W-1:0] rst_cause,
    output logic [DATA_W-1:0] rst_mask,
    output logic [DATA_W-1:0] retain,
    output logic [DATA_W-1:0] boot_vec,
    output logic [DATA_W-1:0] cpu_wait,
    output logic [DATA_W-1:0] wake_ctrl
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] wdata_m;
    logic [DATA_W-1:0] rdata_m;
    acc_class_t        cls;
    logic              accept;
    logic              err_cond;
    logic              rst_cond;

    assign word = paddr[ADDR_W-1:2];
    assign cls  = classify(word);

    always_comb begin
        unique case (acc_size_e'(psize))
            SZ_BYTE:          size_mask = DATA_W'(8'hFF);
            SZ_HALF:          size_mask = DATA_W'(16'hFFFF);
            SZ_WORD, SZ_WRD2: size_mask = '1;
        endcase
    end

    assign wdata_m  = pwdata & size_mask;
    assign err_cond = !cls.mapped || (pwrite && !cls.wr_ok) || (!pwrite && !cls.rd_ok);
    assign rst_cond = pwrite && (word == W_SWRST) && wdata_m[SWRST_BIT];

    sysctl_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .err_cond  (err_cond),
        .rst_cond  (rst_cond),
        .accept    (accept),
        .err_pulse (err_pulse),
        .swrst_req (swrst_req)
    );

    sysctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && pwrite && cls.wr_ok),
        .word     (word),
        .wdata    (wdata_m),
        .sdbg_q   (sdbg_status),
        .cause_q  (rst_cause),
        .mask_q   (rst_mask),
        .retain_q (retain),
        .boot_q   (boot_vec),
        .wait_q   (cpu_wait),
        .wake_q   (wake_ctrl)
    );

    sysctl_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .word      (word),
        .size_mask (size_mask),
        .sdbg_q    (sdbg_status),
        .cause_q   (rst_cause),
        .mask_q    (rst_mask),
        .retain_q  (retain),
        .boot_q    (boot_vec),
        .wait_q    (cpu_wait),
        .wake_q    (wake_ctrl),
        .rdata     (rdata_m)
    );

    assign pready = accept;
    assign prdata = (accept && !pwrite) ? rdata_m : '0;

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              err_pulse,
    input logic              swrst_req,
    input logic [DATA_W-1:0] sdbg_status,
    input logic [DATA_W-1:0] boot_vec
);

    localparam int WORD_W = ADDR_W - 2;
    logic [WORD_W-1:0] cw;
    assign cw = paddr[ADDR_W-1:2];

    p_swrst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> !swrst_req);

    p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && !pwrite && cw == W_RSVD) |-> prdata == '0);

    p_wo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && !pwrite && (cw == W_DBG_SET || cw == W_DBG_CLR || cw == W_SWRST))
        |-> prdata == '0);

    p_boot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pready && pwrite && cw == W_BOOTVEC) |-> $stable(boot_vec));

    p_sdbg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pready && pwrite && cw == W_DBG_SET)
        |-> ((sdbg_status & ~$past(sdbg_status)) == '0));

    p_ready_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> $past(psel && !penable));

endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .prdata      (prdata),
    .pready      (pready),
    .err_pulse   (err_pulse),
    .swrst_req   (swrst_req),
    .sdbg_status (sdbg_status),
    .boot_vec    (boot_vec)
);

// File: tb/sysctl_bank_bench.sv
`timescale 1ns/1ps
module sysctl_bank_bench;

    localparam int CLK_P = 10;
    localparam int Q = CLK_P / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [1:0]  psize = 2'd2;
    logic [31:0] prdata;
    logic        pready;
    logic        err_pulse;
    logic        swrst_req;
    logic [31:0] sdbg_status, rst_cause, rst_mask, retain, boot_vec, cpu_wait, wake_ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    sysctl_bank u_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .psize(psize), .prdata(prdata), .pready(pready),
        .err_pulse(err_pulse), .swrst_req(swrst_req), .sdbg_status(sdbg_status),
        .rst_cause(rst_cause), .rst_mask(rst_mask), .retain(retain), .boot_vec(boot_vec),
        .cpu_wait(cpu_wait), .wake_ctrl(wake_ctrl)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares read data of every accepted read against the scoreboard
    always begin
        @(negedge clk);
        #(Q);
        if (psel && penable && !pwrite && pready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R? unexpected read", prdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(prdata == e, t, prdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz,
                          input bit exp_err, input bit exp_rst, input string tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; psize = sz;
        @(negedge clk);
        penable = 1'b1;
        #(Q);
        chk(pready == 1'b1, "R11 ready on write", 32'(pready), 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #(Q);
        chk(err_pulse == exp_err, {"R10 err after write ", tag}, 32'(err_pulse), 32'(exp_err));
        chk(swrst_req == exp_rst, {"R4 reset req ", tag}, 32'(swrst_req), 32'(exp_rst));
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] exp,
                          input bit exp_err, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; psize = sz;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #(Q);
        chk(err_pulse == exp_err, {"R10 err after read ", tag}, 32'(err_pulse), 32'(exp_err));
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ids [12];
        ids = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8, 8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(Q);
        // R1 reset state at the ports
        chk(rst_cause == 32'h1, "R1 rst_cause", rst_cause, 32'h1);
        chk(boot_vec == 32'h1000_0000, "R1 boot_vec", boot_vec, 32'h1000_0000);
        chk(sdbg_status == 0, "R1 sdbg", sdbg_status, 0);
        chk(rst_mask == 0, "R1 rst_mask", rst_mask, 0);
        chk(retain == 0, "R1 retain", retain, 0);
        chk(cpu_wait == 0, "R1 cpu_wait", cpu_wait, 0);
        chk(wake_ctrl == 0, "R1 wake_ctrl", wake_ctrl, 0);
        chk(!swrst_req && !err_pulse, "R1 strobes", {30'h0, swrst_req, err_pulse}, 0);
        bus_rd(12'h100, 2'd2, 32'h1, 1'b0, "R1 read cause");
        bus_rd(12'h110, 2'd2, 32'h1000_0000, 1'b0, "R1 read boot");

        // R5 / R12 plain registers
        bus_wr(12'h10C, 32'hA5A5_1234, 2'd2, 0, 0, "R5 retain");
        bus_rd(12'h10C, 2'd2, 32'hA5A5_1234, 0, "R12 retain readback");
        bus_wr(12'h104, 32'h0000_00FF, 2'd2, 0, 0, "R5 mask");
        bus_rd(12'h104, 2'd2, 32'h0000_00FF, 0, "R5 mask readback");
        bus_wr(12'h118, 32'h3, 2'd2, 0, 0, "R5 wait");
        bus_rd(12'h118, 2'd2, 32'h3, 0, "R5 wait readback");
        bus_wr(12'h120, 32'h1, 2'd2, 0, 0, "R5 wake");
        bus_rd(12'h120, 2'd2, 32'h1, 0, "R5 wake readback");
        bus_wr(12'h110, 32'h2000_0000, 2'd2, 0, 0, "R5 boot");
        bus_rd(12'h110, 2'd2, 32'h2000_0000, 0, "R5 boot readback");
        chk(boot_vec == 32'h2000_0000, "R5 boot port", boot_vec, 32'h2000_0000);
        bus_wr(12'h100, 32'h8, 2'd2, 0, 0, "R5 cause");
        bus_rd(12'h100, 2'd2, 32'h8, 0, "R5 cause readback");

        // R2 set / clear aliases
        bus_wr(12'h004, 32'h0000_00F3, 2'd2, 0, 0, "R2 set");
        bus_rd(12'h000, 2'd2, 32'h0000_00F3, 0, "R2 status after set");
        bus_wr(12'h004, 32'h0000_0100, 2'd2, 0, 0, "R2 set more");
        bus_wr(12'h008, 32'h0000_0003, 2'd2, 0, 0, "R2 clear");
        bus_rd(12'h000, 2'd2, 32'h0000_01F0, 0, "R2 status after clear");
        bus_wr(12'h000, 32'hFFFF_FFFF, 2'd2, 1, 0, "R2 write to status");
        bus_rd(12'h000, 2'd2, 32'h0000_01F0, 0, "R2 status unchanged");
        chk(sdbg_status == 32'h1F0, "R2 status port", sdbg_status, 32'h1F0);

        // R3 write-only offsets
        bus_rd(12'h004, 2'd2, 32'h0, 1, "R3 read set alias");
        bus_rd(12'h008, 2'd2, 32'h0, 1, "R3 read clear alias");
        bus_rd(12'h108, 2'd2, 32'h0, 1, "R3 read swrst");

        // R4 software reset
        bus_wr(12'h108, 32'h0000_0200, 2'd2, 0, 1, "R4 bit9");
        @(negedge clk); #(Q);
        chk(swrst_req == 1'b0, "R4 pulse one cycle", 32'(swrst_req), 0);
        bus_wr(12'h108, 32'hFFFF_FDFF, 2'd2, 0, 0, "R4 other bits");

        // R6 reserved
        bus_wr(12'h11C, 32'hFFFF_FFFF, 2'd2, 1, 0, "R6 write reserved");
        bus_rd(12'h11C, 2'd2, 32'h0, 0, "R6 read reserved");

        // R7 ID words
        for (int i = 0; i < 12; i++) begin
            bus_rd(12'hFD0 + 12'(4 * i), 2'd2, 32'(ids[i]), 0, "R7 id word");
        end
        bus_wr(12'hFE0, 32'hFFFF_FFFF, 2'd2, 1, 0, "R7 write id");
        bus_rd(12'hFE0, 2'd2, 32'h54, 0, "R7 id unchanged");

        // R8 unmapped
        bus_rd(12'h114, 2'd2, 32'h0, 1, "R8 read hole");
        bus_rd(12'h800, 2'd2, 32'h0, 1, "R8 read far");
        bus_wr(12'h114, 32'hFFFF_FFFF, 2'd2, 1, 0, "R8 write hole");
        bus_wr(12'h500, 32'hFFFF_FFFF, 2'd2, 1, 0, "R8 write far");
        chk(retain == 32'hA5A5_1234 && rst_mask == 32'hFF && cpu_wait == 32'h3 &&
            wake_ctrl == 32'h1 && boot_vec == 32'h2000_0000 && rst_cause == 32'h8 &&
            sdbg_status == 32'h1F0, "R8 registers untouched", retain, 32'hA5A5_1234);

        // R9 narrow accesses
        bus_wr(12'h10C, 32'hDEAD_BEEF, 2'd0, 0, 0, "R9 byte write");
        bus_rd(12'h10C, 2'd2, 32'h0000_00EF, 0, "R9 byte zero-extend");
        bus_wr(12'h10C, 32'hDEAD_BEEF, 2'd1, 0, 0, "R9 half write");
        bus_rd(12'h10C, 2'd2, 32'h0000_BEEF, 0, "R9 half zero-extend");
        bus_wr(12'h10C, 32'h1234_5678, 2'd2, 0, 0, "R9 word write");
        bus_rd(12'h10C, 2'd0, 32'h0000_0078, 0, "R9 byte read");
        bus_rd(12'h10C, 2'd1, 32'h0000_5678, 0, "R9 half read");
        bus_wr(12'h108, 32'h0000_0200, 2'd0, 0, 0, "R9 byte swrst masked");
        bus_wr(12'h004, 32'hFFFF_0200, 2'd1, 0, 0, "R9 half set");
        chk(sdbg_status == 32'h3F0, "R9 half set port", sdbg_status, 32'h3F0);

        // R11 access phase without setup
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h10C; pwdata = 32'hFFFF_FFFF; psize = 2'd2;
        #(Q);
        chk(pready == 1'b0, "R11 stray not ready", 32'(pready), 0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #(Q);
        chk(retain == 32'h1234_5678, "R11 stray no write", retain, 32'h1234_5678);
        bus_rd(12'h10C, 2'd2, 32'h1234_5678, 0, "R11 readback after stray");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule